// File: doc/BRIEF.md
# Keyboard Scan-Code Receiver

This block takes in scan codes from a PC/XT-type keyboard that talks over a pair of open-collector lines, one for clock and one for data. Each line is first brought into the system clock domain. The block then looks for high-to-low transitions of the keyboard clock. On each such transition it shifts the synchronized data level into the top of a nine-bit receive register.

A frame on the wire is a leading 0, then a 1 that acts as a marker, then eight data bits sent least significant first. The receive register starts out all zero. When the marker bit lands in the bottom bit of the register, the frame is complete. That same bit raises the interrupt and pulls the data line low, so the keyboard holds off sending more. No separate bit counter is kept.

The host controls the block with two level inputs. The first is an enable bit: holding it low empties the register and freezes it. The second is a clock-hold bit that pulls the keyboard clock line low. The host reads the received byte on an eight-bit output.

Top module: `xtkbd_receiver`

## Requirements
- R1: While `host_enable_i` is 1, each counted falling edge of the keyboard clock shifts the receive register right by one place and loads the synchronized data level into its top bit (bit 8). The register updates within SYNC_STAGES+2 system clock cycles after the clock line falls.
- R2: Only a transition of the synchronized keyboard clock from 1 to 0 counts as an edge. A rising transition, or a level that stays constant, leaves the register unchanged.
- R3: `kbd_data_pull_o` equals register bit 0. When it is 1, the data line is driven low; when it is 0, the line is released.
- R4: `kbd_irq_o` is 1 exactly while register bit 0 is 1. For a well-formed frame it first rises after the tenth counted falling edge.
- R5: While `host_enable_i` is 0, the register is held at zero and ignores keyboard clock edges. As a result, `scan_code_o` reads 0, and both `kbd_irq_o` and `kbd_data_pull_o` are 0.
- R6: `scan_code_o` is register bits 8:1. After a full frame, `scan_code_o` bit 0 holds the first data bit received and bit 7 holds the last.
- R7: `kbd_clk_pull_o` follows `host_clk_hold_i` with one cycle of register delay. A value of 1 drives the keyboard clock line low.
- R8: After reset, the register is zero and `kbd_clk_pull_o` is 0. The synchronizers and the previous-clock state start high, so a line that stays high after reset yields no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kbd_clk_i | input | 1 | Sensed level of the keyboard clock line |
| kbd_data_i | input | 1 | Sensed level of the keyboard data line |
| host_enable_i | input | 1 | Enable bit; 0 clears and locks the receive register |
| host_clk_hold_i | input | 1 | Host request to pull the keyboard clock line low |
| scan_code_o | output | 8 | Received byte, register bits 8:1 |
| kbd_irq_o | output | 1 | Frame-complete interrupt |
| kbd_data_pull_o | output | 1 | 1 drives the keyboard data line low |
| kbd_clk_pull_o | output | 1 | 1 drives the keyboard clock line low |

## Verification
The bench builds the block with its default parameters: a nine-bit frame register and a two-stage synchronizer. It holds each keyboard line level for several system cycles, so the full synchronizer-plus-shift latency is covered every time a bit is sent. Random bit streams are mixed with random enable drops, which exercise clearing in the middle of a frame and edges that arrive while the block is disabled. Directed frames cover all-zero, all-one and alternating bytes, as well as a rising clock edge that carries changed data.

// File: rtl/xtkbd_pkg.sv
package xtkbd_pkg;
    localparam int FRAME_W     = 9;
    localparam int CODE_W      = FRAME_W - 1;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               clk_pull;
    } rx_state_t;
endpackage

// File: rtl/xtkbd_sync.sv
module xtkbd_sync #(
    parameter int         W       = 2,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/xtkbd_fall.sv
module xtkbd_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign fall_o = prev_q & ~level_i;

    AST_FALL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R2
endmodule

// File: rtl/xtkbd_shreg.sv
module xtkbd_shreg
    import xtkbd_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          fall_i,
    input  logic          data_i,
    input  logic          clk_hold_i,
    output logic [FW-1:0] frame_o,
    output logic          clk_pull_o
);
    logic [FW-1:0] frame_d, frame_q;
    logic          pull_d, pull_q;

    always_comb begin
        frame_d = frame_q;
        pull_d  = clk_hold_i;
        if (!enable_i) begin
            frame_d = '0;
        end else if (fall_i) begin
            frame_d = {data_i, frame_q[FW-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            pull_q  <= 1'b0;
        end else begin
            frame_q <= frame_d;
            pull_q  <= pull_d;
        end
    end

    assign frame_o    = frame_q;
    assign clk_pull_o = pull_q;

    AST_CLEAR_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (frame_q == '0)); // R5
    AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !fall_i) |=> $stable(frame_q)); // R2
    AST_SHIFT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && fall_i) |=> (frame_q[FW-2:0] == $past(frame_q[FW-1:1]))
                                 && (frame_q[FW-1] == $past(data_i))); // R1
    AST_CLK_PULL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_hold_i |=> clk_pull_o); // R7
endmodule

// File: rtl/xtkbd_receiver.sv
module xtkbd_receiver
    import xtkbd_pkg::*;
#(
    parameter int FW     = FRAME_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kbd_clk_i,
    input  logic          kbd_data_i,
    input  logic          host_enable_i,
    input  logic          host_clk_hold_i,
    output logic [FW-2:0] scan_code_o,
    output logic          kbd_irq_o,
    output logic          kbd_data_pull_o,
    output logic          kbd_clk_pull_o
);
    localparam int CW = FW - 1;

    logic [1:0]    lines_s;
    logic          fall;
    logic [FW-1:0] frame;

    xtkbd_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b11)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({kbd_clk_i, kbd_data_i}),
        .q_o   (lines_s)
    );

    xtkbd_fall i_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (lines_s[1]),
        .fall_o  (fall)
    );

    xtkbd_shreg #(.FW(FW)) i_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (host_enable_i),
        .fall_i     (fall),
        .data_i     (lines_s[0]),
        .clk_hold_i (host_clk_hold_i),
        .frame_o    (frame),
        .clk_pull_o (kbd_clk_pull_o)
    );

    assign scan_code_o     = frame[CW:1];
    assign kbd_irq_o       = frame[0];
    assign kbd_data_pull_o = frame[0];

    AST_IRQ_HELD_UNTIL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_irq_o && host_enable_i && !fall) |=> kbd_irq_o); // R4
    AST_PULL_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_data_pull_o == kbd_irq_o); // R3
endmodule

// File: tb/test_xtkbd_receiver.sv
module test_xtkbd_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kbd_clk = 1'b1;
    logic       kbd_data = 1'b1;
    logic       en = 1'b0;
    logic       hold = 1'b0;
    logic [7:0] scan;
    logic       irq, dpull, cpull;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [8:0] m = '0;

    always #5 clk = ~clk;

    xtkbd_receiver i_xtkbd_receiver (
        .clk             (clk),
        .rst_n           (rst_n),
        .kbd_clk_i       (kbd_clk),
        .kbd_data_i      (kbd_data),
        .host_enable_i   (en),
        .host_clk_hold_i (hold),
        .scan_code_o     (scan),
        .kbd_irq_o       (irq),
        .kbd_data_pull_o (dpull),
        .kbd_clk_pull_o  (cpull)
    );

    function automatic logic [8:0] model_shift(logic [8:0] r, logic b);
        return {b, r[8:1]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_all(string req);
        @(negedge clk);
        chk({req, " scan"}, {24'd0, scan}, {24'd0, m[8:1]});
        chk({req, " irq"}, {31'd0, irq}, {31'd0, m[0]});
        chk({req, " dpull"}, {31'd0, dpull}, {31'd0, m[0]});
        #1;
    endtask

    task automatic send_bit(logic b);
        kbd_data = b;
        idle(3);
        kbd_clk = 1'b0;
        idle(6);
        if (en) m = model_shift(m, b);
        kbd_clk = 1'b1;
        idle(6);
        check_all("R1");
    endtask

    task automatic send_frame(logic [7:0] v);
        send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        check_all("R6");
        chk("R4 frame irq", {31'd0, irq}, 32'd1);
    endtask

    task automatic set_en(logic v);
        en = v;
        idle(2);
        if (!v) m = '0;
        check_all("R5");
    endtask

    initial begin
        void'($urandom(32'h1234_5EED));
        idle(3);
        rst_n = 1'b1;
        idle(4);
        // R8 reset state
        @(negedge clk);
        chk("R8 scan", {24'd0, scan}, 32'd0);
        chk("R8 irq", {31'd0, irq}, 32'd0);
        chk("R8 dpull", {31'd0, dpull}, 32'd0);
        chk("R8 cpull", {31'd0, cpull}, 32'd0);
        #1;

        // R5 edges while disabled are ignored
        send_bit(1'b1);
        send_bit(1'b1);
        set_en(1'b1);

        // R4 R6 directed frames
        send_frame(8'h00);
        set_en(1'b0);
        set_en(1'b1);
        send_frame(8'hFF);
        set_en(1'b0);
        set_en(1'b1);
        send_frame(8'hA5);
        set_en(1'b0);
        check_all("R5 cleared after frame");
        set_en(1'b1);

        // R2 rising edge with changed data has no effect
        send_bit(1'b1);
        en = 1'b0;
        kbd_clk = 1'b0;
        idle(6);
        m = '0;
        en = 1'b1;
        idle(4);
        kbd_data = 1'b1;
        kbd_clk = 1'b1;
        idle(8);
        check_all("R2");
        send_bit(1'b0);

        // R7 clock hold
        hold = 1'b1;
        @(negedge clk);
        chk("R7 hold", {31'd0, cpull}, 32'd1);
        #1;
        hold = 1'b0;
        @(negedge clk);
        chk("R7 release", {31'd0, cpull}, 32'd0);
        #1;

        // random frames
        for (int f = 0; f < 12; f++) begin
            set_en(1'b0);
            set_en(1'b1);
            send_frame(8'($urandom));
        end

        // random bit streams with random enable drops
        for (int k = 0; k < 150; k++) begin
            if (($urandom % 8) == 0) set_en(~en);
            send_bit(1'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule